// File: doc/BRIEF.md
# Serial Programming Address and Memory Controller

This block sits behind the command decoder of an in-system programming port. It keeps the programming address counter and performs every access to the nonvolatile word array. The counter is 11 bits wide. On mode entry it points at the configuration word. Its first increment wraps it to zero and hides that word until the next entry. From then on it runs through the 1024-word user region and then the implemented configuration region. That region holds the ID words, a backup calibration word and reserved words.

The array itself lives outside the block, behind a simple port with a combinational read and a single write per cycle. The configuration word is held as a register inside the block, because its protection bit gates every read. Programming is modelled as a fixed number of busy cycles followed by a read-modify-write that can only clear bits. A bulk erase walks the array one word per cycle and writes all ones. How far it walks depends on where the counter points.

Top module: `pgm_mem_ctrl`

## Requirements
- R1: After reset or an entry strobe, `cur_addr` is 0x7FF, `busy` is low, and a read returns the configuration word, which is 0xFFF when erased.
- R2: The first accepted increment makes the configuration word unreachable until the next entry. Addresses 0x440 to 0x7FF then read zero, and programming there changes nothing.
- R3: Each accepted increment adds one to the counter. 0x3FF steps to 0x400 and 0x7FF wraps to 0x000. No command lowers the counter by any other path.
- R4: `read_valid` is high for exactly the one cycle after an accepted read. `read_word[13:12]` is zero and `read_word[11:0]` carries the addressed word.
- R5: When bit 4 of the configuration word is 0, addresses 0x040 to 0x3FE read zero. Addresses 0x000 to 0x03F, 0x3FF and 0x400 to 0x43F still read their stored value.
- R6: A begin strobe is ignored unless a load has been accepted since the last begin. Each accepted begin consumes the loaded word.
- R7: An accepted begin raises `busy` for PROG_CYCLES cycles. It then stores old AND `load_word[11:0]` at the current address, or into the configuration word while that word is selected.
- R8: After the programming time, only an end strobe (or an entry strobe) is accepted. The end strobe returns the block to idle, and increments and reads given before it are ignored.
- R9: A bulk erase given while the configuration word is selected, or while the counter is outside 0x400 to 0x43F, does two things. It sets 0x000 to 0x3FF and the configuration word to 0xFFF and keeps 0x400 to 0x43F. It holds `busy` for 1024 cycles.
- R10: A bulk erase given after an increment, with the counter in 0x400 to 0x43F, sets 0x000 to 0x43F and the configuration word to 0xFFF. It holds `busy` for 1088 cycles.
- R11: While `busy` is high, every strobe except entry is ignored: the counter holds, no read completes, and `mem_we` is only ever high while `busy` is high.
- R12: An entry strobe is accepted at any time. It aborts a programming or erase operation in progress, so no further words are written, and it discards a pending loaded word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, same effect as entry |
| cmd_entry | input | 1 | Mode entry strobe |
| cmd_load | input | 1 | Load word strobe |
| cmd_read | input | 1 | Read word strobe |
| cmd_inc | input | 1 | Increment address strobe |
| cmd_begin | input | 1 | Begin programming strobe |
| cmd_end | input | 1 | End programming strobe |
| cmd_erase | input | 1 | Bulk erase strobe |
| load_word | input | 14 | Data for the load strobe; bits 13:12 are unused |
| read_word | output | 14 | Result of the last read |
| read_valid | output | 1 | One-cycle pulse when `read_word` is updated |
| busy | output | 1 | Programming or erase time in progress |
| cur_addr | output | 11 | Programming address counter |
| mem_addr | output | 11 | Array word index (0 to 0x43F when used) |
| mem_we | output | 1 | Array write enable |
| mem_wdata | output | 12 | Array write data |
| mem_rdata | input | 12 | Array combinational read data at `mem_addr` |

## Verification
The bench fills the array with an arithmetic pattern, then walks the counter over all 2048 values, reading each one. It does this with protection off, with protection on, after a partial erase and after a full erase. Comparing the sweeps separates the masked window from its exact edges (0x03F/0x040 and 0x3FE/0x3FF), the configuration region from the unimplemented range, and the two erase extents. Programming is tried with patterns that clear some bits and try to set others, which shows whether the write is an AND or a plain overwrite. Strobes are also given during busy, while waiting for end, without a prior load, and before an abort by entry, to show which commands are dropped.

// File: rtl/pgm_pkg.sv
package pgm_pkg;
   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_LOAD,
      CMD_READ,
      CMD_INC,
      CMD_BEGIN,
      CMD_END,
      CMD_ERASE
   } cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PROG,
      ST_WAIT_END,
      ST_ERASE
   } seq_state_e;
endpackage

// File: rtl/pgm_addr_ctr.sv
module pgm_addr_ctr #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              entry,
   input  logic              inc_ok,
   output logic [ADDR_W-1:0] addr,
   output logic              cfg_vis
);
   localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

   always_ff @(posedge clk) begin
      if (!rst_n || entry) begin
         addr    <= TOP_ADDR;
         cfg_vis <= 1'b1;
      end else if (inc_ok) begin
         addr    <= addr + 1'b1;
         cfg_vis <= 1'b0;
      end
   end

   p_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
      entry |=> (addr == TOP_ADDR) && cfg_vis);
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_ok && !entry) |=> addr == $past(addr) + 1'b1);
   p_vis_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_ok && !entry) |=> !cfg_vis);
   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_ok && !entry) |=> $stable(addr));
endmodule

// File: rtl/pgm_read_mask.sv
module pgm_read_mask #(
   parameter int ADDR_W     = 11,
   parameter int DATA_W     = 12,
   parameter int USER_DEPTH = 1024,
   parameter int CFG_DEPTH  = 64,
   parameter int OPEN_LOW   = 64,
   parameter int CP_BIT     = 4,
   parameter bit PROT_EN    = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              cfg_vis,
   input  logic [DATA_W-1:0] cfg_word,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] rd_val,
   output logic              prot_hit
);
   localparam logic [ADDR_W-1:0] IMPL_END = ADDR_W'(USER_DEPTH + CFG_DEPTH);
   localparam logic [ADDR_W-1:0] PROT_LO  = ADDR_W'(OPEN_LOW);
   localparam logic [ADDR_W-1:0] PROT_HI  = ADDR_W'(USER_DEPTH - 2);

   logic implemented;
   assign implemented = addr < IMPL_END;

   generate
      if (PROT_EN) begin : g_prot
         assign prot_hit = !cfg_vis && !cfg_word[CP_BIT] &&
                           (addr >= PROT_LO) && (addr <= PROT_HI);
      end else begin : g_open
         assign prot_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      if (cfg_vis)           rd_val = cfg_word;
      else if (!implemented) rd_val = '0;
      else if (prot_hit)     rd_val = '0;
      else                   rd_val = mem_rdata;
   end
endmodule

// File: rtl/pgm_seq.sv
module pgm_seq
   import pgm_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int DATA_W      = 12,
   parameter int USER_DEPTH  = 1024,
   parameter int CFG_DEPTH   = 64,
   parameter int PROG_CYCLES = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              entry,
   input  cmd_e              cmd,
   input  logic [DATA_W-1:0] load_data,
   input  logic [ADDR_W-1:0] addr,
   input  logic              cfg_vis,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              inc_ok,
   output logic              rd_ok,
   output logic              busy,
   output logic [DATA_W-1:0] cfg_word,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata
);
   localparam int PC_W = $clog2(PROG_CYCLES + 1);
   localparam logic [ADDR_W-1:0] USER_END = ADDR_W'(USER_DEPTH);
   localparam logic [ADDR_W-1:0] IMPL_END = ADDR_W'(USER_DEPTH + CFG_DEPTH);
   localparam logic [PC_W-1:0]   PC_LOAD  = PC_W'(PROG_CYCLES - 1);

   seq_state_e        state;
   logic [PC_W-1:0]   pcnt;
   logic [ADDR_W-1:0] walk, walk_last;
   logic              ld_valid;
   logic [DATA_W-1:0] ld_data;
   logic              idle, full_erase, implemented, prog_fire;

   assign idle        = (state == ST_IDLE) && !entry;
   assign inc_ok      = idle && (cmd == CMD_INC);
   assign rd_ok       = idle && (cmd == CMD_READ);
   assign busy        = (state == ST_PROG) || (state == ST_ERASE);
   assign implemented = addr < IMPL_END;
   assign full_erase  = !cfg_vis && (addr >= USER_END) && (addr < IMPL_END);
   assign prog_fire   = (state == ST_PROG) && (pcnt == '0);

   assign mem_addr  = (state == ST_ERASE) ? walk : addr;
   assign mem_we    = (state == ST_ERASE) ||
                      (prog_fire && !cfg_vis && implemented);
   assign mem_wdata = (state == ST_ERASE) ? '1 : (mem_rdata & ld_data);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pcnt      <= '0;
         walk      <= '0;
         walk_last <= '0;
         ld_valid  <= 1'b0;
         ld_data   <= '0;
         cfg_word  <= '1;
      end else if (entry) begin
         state    <= ST_IDLE;
         pcnt     <= '0;
         walk     <= '0;
         ld_valid <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (cmd == CMD_LOAD) begin
                  ld_valid <= 1'b1;
                  ld_data  <= load_data;
               end else if (cmd == CMD_BEGIN && ld_valid) begin
                  ld_valid <= 1'b0;
                  pcnt     <= PC_LOAD;
                  state    <= ST_PROG;
               end else if (cmd == CMD_ERASE) begin
                  cfg_word  <= '1;
                  walk      <= '0;
                  walk_last <= full_erase ? IMPL_END - 1'b1 : USER_END - 1'b1;
                  state     <= ST_ERASE;
               end
            end
            ST_PROG: begin
               if (pcnt == '0) begin
                  if (cfg_vis) cfg_word <= cfg_word & ld_data;
                  state <= ST_WAIT_END;
               end else begin
                  pcnt <= pcnt - 1'b1;
               end
            end
            ST_WAIT_END: begin
               if (cmd == CMD_END) state <= ST_IDLE;
            end
            ST_ERASE: begin
               if (walk == walk_last) state <= ST_IDLE;
               else                   walk  <= walk + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   p_we_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> busy);
   p_begin_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_PROG) && ($past(state) == ST_IDLE)) |-> $past(ld_valid));
   p_prog_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_fire && !entry) |=> (state == ST_WAIT_END) && !busy);
   p_erase_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ERASE) |-> (mem_we && (mem_addr < IMPL_END)));
   p_entry_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
      entry |=> !busy && !ld_valid);
endmodule

// File: rtl/pgm_mem_ctrl.sv
module pgm_mem_ctrl
   import pgm_pkg::*;
#(
   parameter int ADDR_W      = 11,
   parameter int DATA_W      = 12,
   parameter int LOAD_W      = 14,
   parameter int USER_DEPTH  = 1024,
   parameter int CFG_DEPTH   = 64,
   parameter int OPEN_LOW    = 64,
   parameter int CP_BIT      = 4,
   parameter int PROG_CYCLES = 8,
   parameter bit PROT_EN     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_entry,
   input  logic              cmd_load,
   input  logic              cmd_read,
   input  logic              cmd_inc,
   input  logic              cmd_begin,
   input  logic              cmd_end,
   input  logic              cmd_erase,
   input  logic [LOAD_W-1:0] load_word,
   output logic [LOAD_W-1:0] read_word,
   output logic              read_valid,
   output logic              busy,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   generate
      if (USER_DEPTH + CFG_DEPTH >= (1 << ADDR_W))
         $error("user and configuration regions exceed the address space");
      if (LOAD_W <= DATA_W)
         $error("load width must exceed the stored word width");
      if (CP_BIT >= DATA_W || OPEN_LOW >= USER_DEPTH - 1)
         $error("protection parameters out of range");
      if (PROG_CYCLES < 1)
         $error("programming time must be at least one cycle");
   endgenerate

   cmd_e              cmd;
   logic              inc_ok, rd_ok, cfg_vis, prot_hit;
   logic [DATA_W-1:0] cfg_word, rd_val;
   logic [LOAD_W-DATA_W-1:0] unused_load_hi;

   assign unused_load_hi = load_word[LOAD_W-1:DATA_W];

   always_comb begin
      if      (cmd_erase) cmd = CMD_ERASE;
      else if (cmd_begin) cmd = CMD_BEGIN;
      else if (cmd_end)   cmd = CMD_END;
      else if (cmd_inc)   cmd = CMD_INC;
      else if (cmd_load)  cmd = CMD_LOAD;
      else if (cmd_read)  cmd = CMD_READ;
      else                cmd = CMD_NONE;
   end

   pgm_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .entry(cmd_entry), .inc_ok(inc_ok),
      .addr(cur_addr), .cfg_vis(cfg_vis)
   );

   pgm_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .USER_DEPTH(USER_DEPTH),
      .CFG_DEPTH(CFG_DEPTH), .PROG_CYCLES(PROG_CYCLES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .entry(cmd_entry), .cmd(cmd),
      .load_data(load_word[DATA_W-1:0]), .addr(cur_addr), .cfg_vis(cfg_vis),
      .mem_rdata(mem_rdata), .inc_ok(inc_ok), .rd_ok(rd_ok), .busy(busy),
      .cfg_word(cfg_word), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata)
   );

   pgm_read_mask #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .USER_DEPTH(USER_DEPTH),
      .CFG_DEPTH(CFG_DEPTH), .OPEN_LOW(OPEN_LOW), .CP_BIT(CP_BIT),
      .PROT_EN(PROT_EN)
   ) u_mask (
      .addr(cur_addr), .cfg_vis(cfg_vis), .cfg_word(cfg_word),
      .mem_rdata(mem_rdata), .rd_val(rd_val), .prot_hit(prot_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         read_word  <= '0;
         read_valid <= 1'b0;
      end else begin
         read_valid <= rd_ok;
         if (rd_ok) read_word <= {{(LOAD_W-DATA_W){1'b0}}, rd_val};
      end
   end

   p_rd_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      read_valid |-> $past(cmd_read) && !$past(busy));
   p_rd_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
      read_valid |-> (read_word[LOAD_W-1:DATA_W] == '0));
   p_prot_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (read_valid && $past(prot_hit)) |-> (read_word == '0));
endmodule

// File: tb/pgm_mem_ctrl_bench.sv
module pgm_mem_ctrl_bench;
   localparam int NW    = 1088;
   localparam int PCYC  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        c_entry = 0, c_load = 0, c_read = 0, c_inc = 0;
   logic        c_begin = 0, c_end = 0, c_erase = 0;
   logic [13:0] load_word = '0;
   logic [13:0] read_word;
   logic        read_valid, busy, mem_we;
   logic [10:0] cur_addr, mem_addr;
   logic [11:0] mem_wdata, mem_rdata;

   logic [11:0] mem [0:NW-1];
   logic [11:0] exp_mem [0:NW-1];
   logic [11:0] exp_cfg;
   int checks = 0, failures = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   pgm_mem_ctrl u_pgm_mem_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_entry(c_entry), .cmd_load(c_load),
      .cmd_read(c_read), .cmd_inc(c_inc), .cmd_begin(c_begin),
      .cmd_end(c_end), .cmd_erase(c_erase), .load_word(load_word),
      .read_word(read_word), .read_valid(read_valid), .busy(busy),
      .cur_addr(cur_addr), .mem_addr(mem_addr), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   assign mem_rdata = (int'(mem_addr) < NW) ? mem[mem_addr] : 12'h000;
   always @(posedge clk) if (mem_we && int'(mem_addr) < NW) mem[mem_addr] <= mem_wdata;

   function automatic logic [11:0] pat(input int a);
      return 12'((a * 37 + 5) ^ (a >> 3));
   endfunction

   function automatic logic [11:0] exp_read(input int a);
      if (a >= NW) return 12'h000;
      if (!exp_cfg[4] && a >= 'h040 && a <= 'h3FE) return 12'h000;
      return exp_mem[a];
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
      end
   endtask

   // strobe codes: 0 entry 1 load 2 read 3 inc 4 begin 5 end 6 erase
   task automatic cmd(input int c);
      case (c)
         0: c_entry = 1;  1: c_load = 1;  2: c_read = 1;  3: c_inc = 1;
         4: c_begin = 1;  5: c_end = 1;   default: c_erase = 1;
      endcase
      @(negedge clk);
      {c_entry, c_load, c_read, c_inc, c_begin, c_end, c_erase} = '0;
   endtask

   task automatic goto_addr(input int a);
      cmd(0);
      for (int i = 0; i <= a; i++) cmd(3);
   endtask

   task automatic read_chk(input string req, input int expv);
      cmd(2);
      chk(read_valid === 1'b1, req, int'(read_valid), 1);
      chk(read_word === 14'(expv), req, int'(read_word), expv);
   endtask

   task automatic wait_busy(output int n);
      n = 0;
      while (busy === 1'b1) begin n++; @(negedge clk); end
   endtask

   task automatic program_word(input logic [11:0] d, input bit to_cfg, input int a);
      int n;
      load_word = {2'b11, d};
      cmd(1);
      cmd(4);
      wait_busy(n);
      chk(n == PCYC, "R7 program busy length", n, PCYC);
      cmd(5);
      if (to_cfg) exp_cfg = exp_cfg & d;
      else if (a < NW) exp_mem[a] = exp_mem[a] & d;
   endtask

   task automatic sweep(input string req);
      cmd(0);
      for (int a = 0; a < 2048; a++) begin
         cmd(3);
         chk(cur_addr === 11'(a), "R3 counter step", int'(cur_addr), a);
         cmd(2);
         chk(read_word === {2'b00, exp_read(a)}, req, int'(read_word), int'(exp_read(a)));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int n;
      for (int a = 0; a < NW; a++) begin
         mem[a] = pat(a);
         exp_mem[a] = pat(a);
      end
      exp_cfg = 12'hFFF;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(cur_addr === 11'h7FF, "R1 reset address", int'(cur_addr), 'h7FF);
      chk(busy === 1'b0, "R1 reset busy", int'(busy), 0);
      read_chk("R1 config word at entry", 'hFFF);
      // R4 read_valid lasts one cycle
      @(negedge clk);
      chk(read_valid === 1'b0, "R4 read_valid one cycle", int'(read_valid), 0);

      // R3 R4 R2: full sweep, protection off
      sweep("R4 read unprotected sweep");
      // after wrap 0x7FF, config word hidden: R2
      goto_addr(0);
      for (int i = 0; i < 'h7FF; i++) cmd(3);
      chk(cur_addr === 11'h7FF, "R2 counter at top", int'(cur_addr), 'h7FF);
      read_chk("R2 config word hidden after increment", 0);
      cmd(3);
      chk(cur_addr === 11'h000, "R3 wrap to zero", int'(cur_addr), 0);

      // R6 begin without load ignored
      goto_addr(20);
      cmd(4);
      chk(busy === 1'b0, "R6 begin without load", int'(busy), 0);
      read_chk("R6 word unchanged", int'(exp_mem[20]));

      // R7 R8 R11: program at 0x005, AND semantics, ignores while busy
      goto_addr(5);
      load_word = 14'h3A5C;
      cmd(1);
      cmd(4);
      chk(busy === 1'b1, "R7 busy after begin", int'(busy), 1);
      cmd(3);
      chk(cur_addr === 11'h005, "R11 increment ignored while busy", int'(cur_addr), 5);
      cmd(2);
      chk(read_valid === 1'b0, "R11 read ignored while busy", int'(read_valid), 0);
      wait_busy(n);
      chk(n == PCYC - 2, "R7 busy remaining", n, PCYC - 2);
      cmd(3);
      chk(cur_addr === 11'h005, "R8 increment ignored before end", int'(cur_addr), 5);
      cmd(2);
      chk(read_valid === 1'b0, "R8 read ignored before end", int'(read_valid), 0);
      cmd(5);
      exp_mem[5] = exp_mem[5] & 12'hA5C;
      read_chk("R7 stored old AND data", int'(exp_mem[5]));
      cmd(4);
      chk(busy === 1'b0, "R6 load consumed by begin", int'(busy), 0);
      // second programming to the same cell, attempting to set bits
      program_word(12'hFF0, 0, 5);
      read_chk("R7 bits only cleared", int'(exp_mem[5]));

      // R2 programming in unimplemented space has no effect
      goto_addr('h500);
      program_word(12'h000, 0, 'h500);
      read_chk("R2 unimplemented reads zero", 0);

      // R12 entry aborts programming
      goto_addr(10);
      load_word = 14'h0000;
      cmd(1);
      cmd(4);
      cmd(3);
      cmd(0);
      chk(cur_addr === 11'h7FF, "R12 entry resets address", int'(cur_addr), 'h7FF);
      chk(busy === 1'b0, "R12 entry clears busy", int'(busy), 0);
      repeat (PCYC + 2) @(negedge clk);
      cmd(3);
      for (int i = 0; i < 10; i++) cmd(3);
      read_chk("R12 aborted word unchanged", int'(exp_mem[10]));

      // program an ID word and the config word (CP bit 4 cleared)
      goto_addr('h401);
      program_word(12'h00A, 0, 'h401);
      cmd(0);
      program_word(12'hFEF, 1, 0);
      read_chk("R7 config word programmed", int'(exp_cfg));
      // R5 protected sweep
      sweep("R5 protected sweep");

      // R9 erase at entry
      cmd(0);
      cmd(6);
      wait_busy(n);
      chk(n == 1024, "R9 partial erase length", n, 1024);
      for (int a = 0; a < 1024; a++) exp_mem[a] = 12'hFFF;
      exp_cfg = 12'hFFF;
      read_chk("R9 config word erased", 'hFFF);
      sweep("R9 partial erase sweep");

      // R9 erase with counter in user space, after programming 0x100
      goto_addr('h100);
      program_word(12'h123, 0, 'h100);
      cmd(6);
      wait_busy(n);
      chk(n == 1024, "R9 erase from user space length", n, 1024);
      exp_mem['h100] = 12'hFFF;
      read_chk("R9 user word erased", 'hFFF);
      for (int i = 'h100; i < 'h401; i++) cmd(3);
      read_chk("R9 ID kept", int'(exp_mem['h401]));

      // R10 full erase from ID space
      goto_addr('h400);
      cmd(6);
      wait_busy(n);
      chk(n == NW, "R10 full erase length", n, NW);
      for (int a = 0; a < NW; a++) exp_mem[a] = 12'hFFF;
      cmd(3); cmd(3); cmd(3); cmd(3);
      read_chk("R10 backup word erased", 'hFFF);
      sweep("R10 full erase sweep");
      cmd(0);
      read_chk("R10 config word erased", 'hFFF);

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule